// File: doc/BRIEF.md
# Interrupt Flag and Watchdog Restart Register

This block is one byte-wide special-function register that gathers sticky interrupt flags raised by hardware events and also carries the command that restarts the watchdog timer. Each hardware event input sets its flag on the next clock edge. The flag stays set until software clears it. The register answers at one special-function address. The default address is 0xE8.

Software clears flags with a single whole-byte write. A bit written as 0 clears the matching flag. A bit written as 1 leaves that flag as it is. To clear only chosen flags, software writes all ones except at the chosen positions. The top bit works differently on reads and on writes. A read returns the PLL-fall interrupt flag. A write of 0 to that bit clears the flag. A write of 1 to that bit does not touch the flag and instead sends a one-cycle restart pulse to the watchdog. Bit 0 is the transfer-busy flag. Bit 1 and every other position not listed in the implemented-bit mask are reserved.

Each implemented flag is a small two-state machine with the states FL_CLEAR and FL_PENDING. It moves FL_CLEAR→FL_PENDING on a set event. It moves FL_PENDING→FL_CLEAR on a clear when no set arrives in the same cycle. In every other case it holds its state. The restart pulse comes from a two-state machine with the states KS_IDLE and KS_PULSE. It moves KS_IDLE→KS_PULSE on a restart request and stays in KS_PULSE while requests keep arriving on back-to-back writes. It returns KS_PULSE→KS_IDLE when a cycle has no request. It stays in KS_IDLE when there is no request.

Top module: `irq_kick_sfr`

## Requirements
- R1: While reset is asserted and after it is released, every flag output is 0 and `wd_kick` is 0.
- R2: A 1 on `hw_set[i]` for an implemented bit i (default mask 0x81: bit 0 = transfer-busy, bit 7 = PLL-fall) sets `flags[i]` at the next clock edge. The flag then stays 1 with no further event until software clears it.
- R3: A write (`sfr_we`=1, `sfr_addr`=0xE8) clears at the next edge each implemented flag whose `sfr_wdata` bit is 0. Every flag whose written bit is 1 keeps its value.
- R4: When a set event and a write-0 clear reach the same flag in the same cycle, the flag is 1 after the edge.
- R5: A write to 0xE8 with `sfr_wdata[7]`=1 drives `wd_kick` to 1 for exactly the one cycle after that edge, and flag 7 keeps its value. A write with `sfr_wdata[7]`=0 produces no pulse and clears flag 7.
- R6: Reserved bits (bits 1 to 6 with the default mask) always read as 0 on `sfr_rdata` and on `flags`, even when their `hw_set` inputs are 1.
- R7: `sfr_rdata` equals the current flag byte whenever `sfr_addr` is 0xE8, and it is 0 for any other address. A read has no side effect.
- R8: A write to any address other than 0xE8 changes no flag and produces no `wd_kick` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sfr_addr | input | ADDR_W | Special-function address for reads and writes |
| sfr_we | input | 1 | Write strobe, one byte per cycle |
| sfr_wdata | input | DATA_W | Write byte (0 = clear, 1 = keep; top bit 1 = restart) |
| sfr_rdata | output | DATA_W | Read byte, 0 when the address does not match |
| hw_set | input | DATA_W | Per-bit hardware set events |
| flags | output | DATA_W | Current flag values |
| wd_kick | output | 1 | One-cycle watchdog restart pulse |

## Verification
The bench builds the block with its default values: an 8-bit data path, address 0xE8, restart on bit 7, and implemented-bit mask 0x81. This setting brings both the split top bit and a run of six reserved positions within reach. Random writes then exercise clear-with-0 and keep-with-1 on real flags, clear attempts on reserved bits, and set events on bits that do not exist. Because the address is drawn to match about half the time, writes and reads to other addresses mix with the matching ones. Back-to-back restart writes exercise the KS_PULSE→KS_PULSE transition.

// File: rtl/irq_kick_pkg.sv
package irq_kick_pkg;

    typedef enum logic {
        FL_CLEAR   = 1'b0,
        FL_PENDING = 1'b1
    } flag_state_e;

    typedef enum logic {
        KS_IDLE  = 1'b0,
        KS_PULSE = 1'b1
    } kick_state_e;

endpackage

// File: rtl/irq_kick_flag_cell.sv
module irq_kick_flag_cell
    import irq_kick_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_req,
    output logic flag_q
);

    flag_state_e state_q;
    flag_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: a set event always wins over a clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR: begin
                if (set_evt) begin
                    state_d = FL_PENDING;
                end
            end
            FL_PENDING: begin
                if (clr_req && !set_evt) begin
                    state_d = FL_CLEAR;
                end
            end
        endcase
    end

    // Output
    always_comb begin
        flag_q = (state_q == FL_PENDING);
    end

endmodule

// File: rtl/irq_kick_pulse_fsm.sv
module irq_kick_pulse_fsm
    import irq_kick_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic kick_req,
    output logic kick_pulse
);

    kick_state_e state_q;
    kick_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= KS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_IDLE: begin
                if (kick_req) begin
                    state_d = KS_PULSE;
                end
            end
            KS_PULSE: begin
                if (!kick_req) begin
                    state_d = KS_IDLE;
                end
            end
        endcase
    end

    // Output: one cycle high per accepted restart write
    always_comb begin
        kick_pulse = (state_q == KS_PULSE);
    end

endmodule

// File: rtl/irq_kick_decode.sv
module irq_kick_decode #(
    parameter int unsigned            ADDR_W    = 8,
    parameter int unsigned            DATA_W    = 8,
    parameter logic [ADDR_W-1:0]      SFR_ADDR  = 8'hE8,
    parameter int unsigned            KICK_BIT  = 7,
    parameter logic [DATA_W-1:0]      IMPL_MASK = 8'h81
) (
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_we,
    input  logic [DATA_W-1:0] sfr_wdata,
    input  logic [DATA_W-1:0] flag_vec,
    output logic [DATA_W-1:0] clr_vec,
    output logic              kick_req,
    output logic [DATA_W-1:0] rd_data
);

    logic addr_hit;
    logic wr_hit;

    always_comb begin
        addr_hit = (sfr_addr == SFR_ADDR);
        wr_hit   = sfr_we && addr_hit;
        // A bit written as 0 clears; 1 keeps
        clr_vec  = wr_hit ? (~sfr_wdata & IMPL_MASK) : '0;
        kick_req = wr_hit && sfr_wdata[KICK_BIT];
        rd_data  = addr_hit ? (flag_vec & IMPL_MASK) : '0;
    end

endmodule

// File: rtl/irq_kick_sfr.sv
module irq_kick_sfr #(
    parameter int unsigned            ADDR_W    = 8,
    parameter int unsigned            DATA_W    = 8,
    parameter logic [ADDR_W-1:0]      SFR_ADDR  = 8'hE8,
    parameter int unsigned            KICK_BIT  = 7,
    parameter logic [DATA_W-1:0]      IMPL_MASK = 8'h81
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] sfr_addr,
    input  logic              sfr_we,
    input  logic [DATA_W-1:0] sfr_wdata,
    output logic [DATA_W-1:0] sfr_rdata,
    input  logic [DATA_W-1:0] hw_set,
    output logic [DATA_W-1:0] flags,
    output logic              wd_kick
);

    logic [DATA_W-1:0] clr_vec;
    logic [DATA_W-1:0] flag_vec;
    logic              kick_req;
    logic              unused_hw;

    // Events on reserved positions have nowhere to go
    assign unused_hw = ^(hw_set & ~IMPL_MASK);

    irq_kick_decode #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .SFR_ADDR  (SFR_ADDR),
        .KICK_BIT  (KICK_BIT),
        .IMPL_MASK (IMPL_MASK)
    ) u_decode (
        .sfr_addr  (sfr_addr),
        .sfr_we    (sfr_we),
        .sfr_wdata (sfr_wdata),
        .flag_vec  (flag_vec),
        .clr_vec   (clr_vec),
        .kick_req  (kick_req),
        .rd_data   (sfr_rdata)
    );

    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
        if (IMPL_MASK[i]) begin : g_flag
            irq_kick_flag_cell u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .set_evt (hw_set[i]),
                .clr_req (clr_vec[i]),
                .flag_q  (flag_vec[i])
            );
        end else begin : g_rsvd
            assign flag_vec[i] = 1'b0;
        end
    end

    irq_kick_pulse_fsm u_kick (
        .clk        (clk),
        .rst_n      (rst_n),
        .kick_req   (kick_req),
        .kick_pulse (wd_kick)
    );

    assign flags = flag_vec;

endmodule

// File: rtl/irq_kick_sfr_chk.sv
module irq_kick_sfr_chk #(
    parameter int unsigned            ADDR_W    = 8,
    parameter int unsigned            DATA_W    = 8,
    parameter logic [ADDR_W-1:0]      SFR_ADDR  = 8'hE8,
    parameter int unsigned            KICK_BIT  = 7,
    parameter logic [DATA_W-1:0]      IMPL_MASK = 8'h81
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] sfr_addr,
    input logic              sfr_we,
    input logic [DATA_W-1:0] sfr_wdata,
    input logic [DATA_W-1:0] sfr_rdata,
    input logic [DATA_W-1:0] hw_set,
    input logic [DATA_W-1:0] flags,
    input logic              wd_kick
);

    logic wr_hit;
    assign wr_hit = sfr_we && (sfr_addr == SFR_ADDR);

    // R1
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (flags == '0 && !wd_kick));

    assert_set_sticks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((hw_set & IMPL_MASK) != '0) |=>
            ((flags & $past(hw_set & IMPL_MASK)) == $past(hw_set & IMPL_MASK)));

    assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> ((flags & ~$past(sfr_wdata) & ~$past(hw_set) & IMPL_MASK) == '0));

    assert_kick_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && sfr_wdata[KICK_BIT]) |=> wd_kick);

    assert_no_kick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_hit && sfr_wdata[KICK_BIT]) |=> !wd_kick);

    assert_rsvd_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & ~IMPL_MASK) == '0) && ((sfr_rdata & ~IMPL_MASK) == '0));

    assert_read_mux_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_addr != SFR_ADDR) |-> (sfr_rdata == '0));

    assert_foreign_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && hw_set == '0) |=> $stable(flags));

endmodule

bind irq_kick_sfr irq_kick_sfr_chk #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .SFR_ADDR  (SFR_ADDR),
    .KICK_BIT  (KICK_BIT),
    .IMPL_MASK (IMPL_MASK)
) u_chk (.*);

// File: tb/irq_kick_sfr_test.sv
module irq_kick_sfr_test;

    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] ADDR = 8'hE8;
    localparam logic [7:0] MASK = 8'h81;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic       sfr_we = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic [7:0] hw_set = 8'h00;
    logic [7:0] flags;
    logic       wd_kick;

    int n_checks = 0;
    int n_fail = 0;
    logic [7:0] exp_flags = 8'h00;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_kick_sfr uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sfr_addr  (sfr_addr),
        .sfr_we    (sfr_we),
        .sfr_wdata (sfr_wdata),
        .sfr_rdata (sfr_rdata),
        .hw_set    (hw_set),
        .flags     (flags),
        .wd_kick   (wd_kick)
    );

    function automatic logic [7:0] next_flags(input logic [7:0] cur, input logic we,
                                              input logic [7:0] a, input logic [7:0] wd,
                                              input logic [7:0] hw);
        logic [7:0] clr;
        clr = (we && a == ADDR) ? ~wd : 8'h00;
        return ((cur & ~clr) | hw) & MASK;
    endfunction

    function automatic logic next_kick(input logic we, input logic [7:0] a, input logic [7:0] wd);
        return we && (a == ADDR) && wd[7];
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] cur, input logic [7:0] a);
        return (a == ADDR) ? cur : 8'h00;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at negedge, check read data before the edge and state after it
    task automatic step(input logic we, input logic [7:0] a, input logic [7:0] wd,
                        input logic [7:0] hw, input string tag);
        logic [7:0] nf;
        logic       nk;
        sfr_we = we; sfr_addr = a; sfr_wdata = wd; hw_set = hw;
        #1;
        chk({tag, " R7 read"}, sfr_rdata, exp_read(exp_flags, a));
        nf = next_flags(exp_flags, we, a, wd, hw);
        nk = next_kick(we, a, wd);
        @(posedge clk);
        @(negedge clk);
        exp_flags = nf;
        chk({tag, " flags"}, flags, nf);
        chk({tag, " R5 kick"}, {7'd0, wd_kick}, {7'd0, nk});
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int unsigned seed_sink;
        seed_sink = $urandom(32'h1D5E_ED01);
        hw_set = 8'hFF;
        @(negedge clk);
        chk("R1 flags in reset", flags, 8'h00);
        chk("R1 kick in reset", {7'd0, wd_kick}, 8'h00);
        hw_set = 8'h00;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 flags after reset", flags, 8'h00);
        chk("R1 kick after reset", {7'd0, wd_kick}, 8'h00);

        // R2: set and stick
        step(1'b0, 8'h00, 8'h00, 8'h01, "R2 set bit0");
        step(1'b0, 8'h00, 8'h00, 8'h00, "R2 bit0 sticks");
        step(1'b0, 8'h00, 8'h00, 8'h80, "R2 set bit7");
        // R3: write 1 keeps, write 0 clears only the chosen flag
        step(1'b1, ADDR, 8'h7F & 8'hFF, 8'h00, "R3 clear bit7 only");
        step(1'b1, ADDR, 8'hFF, 8'h00, "R3 all ones keeps");
        step(1'b1, ADDR, 8'hFE, 8'h00, "R3 clear bit0");
        // R4: set beats clear
        step(1'b1, ADDR, 8'h7E, 8'h81, "R4 set wins");
        // R5: restart with bit7=1 keeps flag7
        step(1'b1, ADDR, 8'hFF, 8'h00, "R5 kick keeps flag");
        step(1'b1, ADDR, 8'hFF, 8'h00, "R5 back-to-back kick");
        step(1'b0, ADDR, 8'h00, 8'h00, "R5 pulse ends");
        // R8: foreign address writes do nothing
        step(1'b1, 8'hE9, 8'h00, 8'h00, "R8 foreign write");
        step(1'b1, 8'h68, 8'h80, 8'h00, "R8 foreign kick");
        // R6: reserved events ignored
        step(1'b0, 8'h00, 8'h00, 8'h7E, "R6 rsvd events");
        step(1'b0, ADDR, 8'h00, 8'h00, "R6 rsvd read");
        // R7: read other address
        step(1'b0, 8'h12, 8'h00, 8'h00, "R7 other addr");

        for (int i = 0; i < 400; i++) begin
            logic [7:0] a;
            logic [7:0] hw;
            a = ($urandom % 2 == 0) ? ADDR : 8'($urandom);
            hw = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
            step(1'($urandom), a, 8'($urandom), hw, "R2 R3 R4 R6 R8 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule